// File: doc/BRIEF.md
# Privileged Processor Register File

This block holds the internal registers that only privileged code may touch. A core sends it two kinds of request: a move-from, which reads one register into a general-purpose register (GPR), and a move-to, which loads one register from a GPR. Each request names its target with a 16-bit register number. The block decodes that number onto three groups of storage:

- a row of scalar registers;
- an eight-entry shadow bank;
- a twenty-four-entry scratch bank.

The scalar registers differ in width. Numbers 0 and 1 hold 8 bits. Number 2 holds 32 bits. Numbers 3 to 12 hold 64 bits. A read widens the value to 64 bits and a write trims it to the register's width. Numbers that map to nothing read as zero and drop writes. In order, numbers 3 to 12 are:

- three trap arguments;
- the exception address;
- the privileged base;
- the page-table base;
- the virtual page-table pointer;
- the unique value;
- the system value;
- the user stack pointer.

The core samples a request on a clock edge in which `req_valid` is high. A request is accepted only while `priv_mode` is high. An unprivileged request changes no state and instead raises `rsp_illegal` in the following cycle. For an accepted move-from, the widened value appears on `rsp_rdata` in the following cycle, together with a one-cycle `rsp_wen` pulse. That pulse is what writes the value into the destination GPR. GPR index 31 acts as the zero register. Reading into it produces no write-back. Writing from it stores zero.

Top module: `privreg_file`

## Requirements
- R1: After reset, number 1 (floating-enable) reads 1 and every other register reads 0. During reset and in the first cycle after it, `rsp_wen`, `rsp_illegal` and `rsp_rdata` are all 0.
- R2: Numbers 0 and 1 are 8-bit registers. A read returns bits 7:0 zero-extended to 64 bits. A write keeps only bits 7:0 of the source.
- R3: Number 2 is a 32-bit register. A read copies bit 31 into bits 63:32. A write keeps only bits 31:0 of the source.
- R4: Numbers 3 through 12 are ten independent 64-bit registers that store the whole source value.
- R5: Numbers 32 to 39 address shadow entries 0 to 7, and numbers 40 to 63 address scratch entries 0 to 23. Each entry is an independent 64-bit register.
- R6: Every other 16-bit number, including 13 to 31 and all values of 64 and above, reads as 0. A write to such a number changes no register, even when its low six bits match a mapped number.
- R7: A move-from whose GPR index is 31 produces no `rsp_wen` pulse, leaves `rsp_rdata` at 0 and changes no register.
- R8: A move-to whose GPR index is 31 stores zero, whatever is on `req_wdata`.
- R9: A request made while `priv_mode` is 0 raises `rsp_illegal` for exactly the following cycle. It produces no `rsp_wen` and changes no register.
- R10: `req_write` = 1 selects a move-to and `req_write` = 0 selects a move-from. An accepted move-from drives `rsp_wen` = 1 and the widened value on `rsp_rdata` in the cycle after the request. A move-to is visible to a move-from issued in the next cycle. `rsp_rdata` is 0 whenever `rsp_wen` is 0.
- R11: `rsp_illegal` stays 0 for privileged requests. A cycle with `req_valid` low produces no response and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_regnum | input | 16 | Register number |
| req_wdata | input | 64 | Source GPR value for a move-to |
| req_gpr | input | 5 | Source or destination GPR index; 31 is the zero register |
| priv_mode | input | 1 | Core is in privileged mode |
| rsp_rdata | output | 64 | Widened read value, valid with rsp_wen |
| rsp_wen | output | 1 | Destination GPR write enable, one-cycle pulse |
| rsp_illegal | output | 1 | Illegal-opcode indication, one-cycle pulse |

## Verification
The bench writes values into the 8-bit and 32-bit registers with the upper bits set. A design that extends the wrong way, or fails to trim on write, returns upper bits that should be gone. It also writes to numbers such as 0x0100 and 0x0120, whose low six bits alias mapped registers. A decoder that looks only at the low bits would then corrupt register 0 or shadow entry 0. GPR index 31 is tried in both directions: a design that writes back from a discarded read pulses `rsp_wen`, and one that stores the source value instead of zero leaves data behind. Unprivileged requests and idle cycles carrying write-like fields are followed by privileged reads, which expose any state changed by a request that should have been rejected.

// File: rtl/privreg_pkg.sv
package privreg_pkg;

    localparam int DATA_W = 64;

    // Storage shape of one decoded register number
    typedef enum logic [1:0] {
        WC_NONE = 2'd0,
        WC_BYTE = 2'd1,
        WC_WORD = 2'd2,
        WC_QUAD = 2'd3
    } width_cls_t;

    typedef struct packed {
        logic              wen;
        logic              illegal;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    // Trim a source value to the width of its register
    function automatic logic [DATA_W-1:0] fit_write(width_cls_t cls, logic [DATA_W-1:0] src);
        case (cls)
            WC_BYTE: fit_write = {{(DATA_W-8){1'b0}}, src[7:0]};
            WC_WORD: fit_write = {{(DATA_W-32){1'b0}}, src[31:0]};
            WC_QUAD: fit_write = src;
            default: fit_write = '0;
        endcase
    endfunction

    // Widen a stored value to the full read width
    function automatic logic [DATA_W-1:0] widen_read(width_cls_t cls, logic [DATA_W-1:0] raw);
        case (cls)
            WC_BYTE: widen_read = {{(DATA_W-8){1'b0}}, raw[7:0]};
            WC_WORD: widen_read = {{(DATA_W-32){raw[31]}}, raw[31:0]};
            WC_QUAD: widen_read = raw;
            default: widen_read = '0;
        endcase
    endfunction

endpackage

// File: rtl/privreg_decode.sv
module privreg_decode
    import privreg_pkg::*;
#(
    parameter int NUM_W        = 16,
    parameter int WORD_NUM     = 2,
    parameter int SCALAR_N     = 13,
    parameter int SHADOW_BASE  = 32,
    parameter int SHADOW_N     = 8,
    parameter int SCRATCH_BASE = 40,
    parameter int SCRATCH_N    = 24,
    parameter int SLOT_W       = 6
) (
    input  logic [NUM_W-1:0]  regnum,
    output width_cls_t        cls,
    output logic [SLOT_W-1:0] slot
);
    localparam int SHADOW_END  = SHADOW_BASE + SHADOW_N;
    localparam int SCRATCH_END = SCRATCH_BASE + SCRATCH_N;
    localparam int SHADOW_OFS  = SCALAR_N;
    localparam int SCRATCH_OFS = SCALAR_N + SHADOW_N;

    int num_i;

    always_comb begin
        num_i = int'(regnum);
        cls   = WC_NONE;
        slot  = '0;
        if (num_i < WORD_NUM) begin
            cls  = WC_BYTE;
            slot = SLOT_W'(num_i);
        end else if (num_i == WORD_NUM) begin
            cls  = WC_WORD;
            slot = SLOT_W'(num_i);
        end else if (num_i < SCALAR_N) begin
            cls  = WC_QUAD;
            slot = SLOT_W'(num_i);
        end else if (num_i >= SHADOW_BASE && num_i < SHADOW_END) begin
            cls  = WC_QUAD;
            slot = SLOT_W'(num_i - SHADOW_BASE + SHADOW_OFS);
        end else if (num_i >= SCRATCH_BASE && num_i < SCRATCH_END) begin
            cls  = WC_QUAD;
            slot = SLOT_W'(num_i - SCRATCH_BASE + SCRATCH_OFS);
        end
    end

endmodule

// File: rtl/privreg_store.sv
module privreg_store
    import privreg_pkg::*;
#(
    parameter int NSLOT    = 45,
    parameter int SLOT_W   = 6,
    parameter int FEN_SLOT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data
);
    logic [NSLOT-1:0][DATA_W-1:0] slots_q;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [DATA_W-1:0] RST_VAL = (s == FEN_SLOT) ? DATA_W'(1) : '0;
        logic [DATA_W-1:0] val_d;
        logic [DATA_W-1:0] val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (int'(wr_slot) == s)) begin
                val_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= RST_VAL;
            end else begin
                val_q <= val_d;
            end
        end

        assign slots_q[s] = val_q;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_slot) < NSLOT) begin
            rd_data = slots_q[rd_slot];
        end
    end

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slots_q)) else $error("store changed without write"); // R9

endmodule

// File: rtl/privreg_file.sv
module privreg_file
    import privreg_pkg::*;
#(
    parameter int NUM_W        = 16,
    parameter int GPR_W        = 5,
    parameter int WORD_NUM     = 2,
    parameter int FEN_NUM      = 1,
    parameter int SCALAR_N     = 13,
    parameter int SHADOW_BASE  = 32,
    parameter int SHADOW_N     = 8,
    parameter int SCRATCH_BASE = 40,
    parameter int SCRATCH_N    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [NUM_W-1:0]  req_regnum,
    input  logic [63:0]       req_wdata,
    input  logic [GPR_W-1:0]  req_gpr,
    input  logic              priv_mode,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_wen,
    output logic              rsp_illegal
);
    localparam int NSLOT = SCALAR_N + SHADOW_N + SCRATCH_N;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam logic [GPR_W-1:0] ZERO_GPR = '1;

    width_cls_t        dec_cls;
    logic [SLOT_W-1:0] dec_slot;
    logic              accept;
    logic              zero_gpr;
    logic              st_wr_en;
    logic [DATA_W-1:0] st_wr_data;
    logic [DATA_W-1:0] st_rd_data;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    privreg_decode #(
        .NUM_W       (NUM_W),
        .WORD_NUM    (WORD_NUM),
        .SCALAR_N    (SCALAR_N),
        .SHADOW_BASE (SHADOW_BASE),
        .SHADOW_N    (SHADOW_N),
        .SCRATCH_BASE(SCRATCH_BASE),
        .SCRATCH_N   (SCRATCH_N),
        .SLOT_W      (SLOT_W)
    ) u_decode (
        .regnum(req_regnum),
        .cls   (dec_cls),
        .slot  (dec_slot)
    );

    privreg_store #(
        .NSLOT   (NSLOT),
        .SLOT_W  (SLOT_W),
        .FEN_SLOT(FEN_NUM)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (st_wr_en),
        .wr_slot(dec_slot),
        .wr_data(st_wr_data),
        .rd_slot(dec_slot),
        .rd_data(st_rd_data)
    );

    // Request qualification and write shaping
    always_comb begin
        accept     = req_valid && priv_mode;
        zero_gpr   = (req_gpr == ZERO_GPR);
        st_wr_en   = accept && req_write && (dec_cls != WC_NONE);
        st_wr_data = fit_write(dec_cls, zero_gpr ? '0 : req_wdata);
    end

    // Next response
    always_comb begin
        rsp_d = '0;
        if (req_valid && !priv_mode) begin
            rsp_d.illegal = 1'b1;
        end else if (accept && !req_write && !zero_gpr) begin
            rsp_d.wen   = 1'b1;
            rsp_d.rdata = widen_read(dec_cls, st_rd_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_rdata   = rsp_q.rdata;
    assign rsp_wen     = rsp_q.wen;
    assign rsp_illegal = rsp_q.illegal;

    AST_UNPRIV_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !priv_mode) |=> (rsp_illegal && !rsp_wen)) else $error("unpriv not flagged"); // R9
    AST_PRIV_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_mode) |=> !rsp_illegal) else $error("priv flagged"); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_illegal && !rsp_wen)) else $error("idle response"); // R11
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_mode && !req_write && req_gpr != ZERO_GPR) |=> rsp_wen) else $error("no wen"); // R10
    AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_gpr == ZERO_GPR) |=> !rsp_wen) else $error("wen to r31"); // R7
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_wen |-> (rsp_rdata == '0)) else $error("rdata without wen"); // R10
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_wen, rsp_illegal}) <= 1) else $error("both flags"); // R9

endmodule

// File: tb/privreg_file_test.sv
module privreg_file_test;

    typedef struct packed {
        logic        v;
        logic        wr;
        logic [15:0] num;
        logic [63:0] data;
        logic [4:0]  gpr;
        logic        priv;
        logic        e_wen;
        logic        e_ill;
        logic [63:0] e_rd;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 16'd1,     64'h0,                   5'd1,  1'b1, 1'b1, 1'b0, 64'h1,                   8'd1},  // R1 fen
        '{1'b1, 1'b0, 16'd0,     64'h0,                   5'd1,  1'b1, 1'b1, 1'b0, 64'h0,                   8'd1},  // R1 ps
        '{1'b1, 1'b1, 16'd0,     64'hFFFF_FFFF_FFFF_FFA5, 5'd2,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd2},  // R2
        '{1'b1, 1'b0, 16'd0,     64'h0,                   5'd2,  1'b1, 1'b1, 1'b0, 64'hA5,                  8'd2},  // R2
        '{1'b1, 1'b1, 16'd1,     64'h0000_0000_0000_0300, 5'd2,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd2},  // R2
        '{1'b1, 1'b0, 16'd1,     64'h0,                   5'd2,  1'b1, 1'b1, 1'b0, 64'h0,                   8'd2},  // R2
        '{1'b1, 1'b1, 16'd2,     64'h1234_5678_8000_0001, 5'd2,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd3},  // R3
        '{1'b1, 1'b0, 16'd2,     64'h0,                   5'd2,  1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_8000_0001, 8'd3},  // R3
        '{1'b1, 1'b1, 16'd2,     64'hFFFF_FFFF_7FFF_FFFF, 5'd2,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd3},  // R3
        '{1'b1, 1'b0, 16'd2,     64'h0,                   5'd2,  1'b1, 1'b1, 1'b0, 64'h0000_0000_7FFF_FFFF, 8'd3},  // R3
        '{1'b1, 1'b1, 16'd3,     64'h0123_4567_89AB_CDEF, 5'd4,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd4},  // R4
        '{1'b1, 1'b1, 16'd12,    64'hFEDC_BA98_7654_3210, 5'd4,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd4},  // R4
        '{1'b1, 1'b0, 16'd3,     64'h0,                   5'd4,  1'b1, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 8'd4},  // R4
        '{1'b1, 1'b0, 16'd12,    64'h0,                   5'd4,  1'b1, 1'b1, 1'b0, 64'hFEDC_BA98_7654_3210, 8'd4},  // R4
        '{1'b1, 1'b1, 16'd32,    64'hAAAA_0000_0000_0032, 5'd6,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd5},  // R5
        '{1'b1, 1'b1, 16'd39,    64'h0000_0000_0000_0039, 5'd6,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd5},  // R5
        '{1'b1, 1'b1, 16'd40,    64'h4000_0000_0000_0040, 5'd6,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd5},  // R5
        '{1'b1, 1'b1, 16'd63,    64'h8000_0000_0000_0063, 5'd6,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd5},  // R5
        '{1'b1, 1'b0, 16'd32,    64'h0,                   5'd6,  1'b1, 1'b1, 1'b0, 64'hAAAA_0000_0000_0032, 8'd5},  // R5
        '{1'b1, 1'b0, 16'd39,    64'h0,                   5'd6,  1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0039, 8'd5},  // R5
        '{1'b1, 1'b0, 16'd40,    64'h0,                   5'd6,  1'b1, 1'b1, 1'b0, 64'h4000_0000_0000_0040, 8'd5},  // R5
        '{1'b1, 1'b0, 16'd63,    64'h0,                   5'd6,  1'b1, 1'b1, 1'b0, 64'h8000_0000_0000_0063, 8'd5},  // R5
        '{1'b1, 1'b1, 16'd13,    64'h0000_0000_0000_DEAD, 5'd7,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd6},  // R6
        '{1'b1, 1'b0, 16'd13,    64'h0,                   5'd7,  1'b1, 1'b1, 1'b0, 64'h0,                   8'd6},  // R6
        '{1'b1, 1'b1, 16'h0100,  64'h0000_0000_0000_0077, 5'd7,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd6},  // R6
        '{1'b1, 1'b0, 16'd0,     64'h0,                   5'd7,  1'b1, 1'b1, 1'b0, 64'hA5,                  8'd6},  // R6
        '{1'b1, 1'b1, 16'h0120,  64'h0000_0000_0000_5555, 5'd7,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd6},  // R6
        '{1'b1, 1'b0, 16'd32,    64'h0,                   5'd7,  1'b1, 1'b1, 1'b0, 64'hAAAA_0000_0000_0032, 8'd6},  // R6
        '{1'b1, 1'b0, 16'h0040,  64'h0,                   5'd7,  1'b1, 1'b1, 1'b0, 64'h0,                   8'd6},  // R6
        '{1'b1, 1'b1, 16'd31,    64'h0000_0000_0000_0001, 5'd7,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd6},  // R6
        '{1'b1, 1'b0, 16'd31,    64'h0,                   5'd7,  1'b1, 1'b1, 1'b0, 64'h0,                   8'd6},  // R6
        '{1'b1, 1'b1, 16'd5,     64'h0000_0000_0000_1111, 5'd3,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd8},  // R8
        '{1'b1, 1'b0, 16'd5,     64'h0,                   5'd3,  1'b1, 1'b1, 1'b0, 64'h1111,                8'd10}, // R10
        '{1'b1, 1'b1, 16'd5,     64'h0000_0000_0000_5555, 5'd31, 1'b1, 1'b0, 1'b0, 64'h0,                   8'd8},  // R8
        '{1'b1, 1'b0, 16'd5,     64'h0,                   5'd3,  1'b1, 1'b1, 1'b0, 64'h0,                   8'd8},  // R8
        '{1'b1, 1'b0, 16'd3,     64'h0,                   5'd31, 1'b1, 1'b0, 1'b0, 64'h0,                   8'd7},  // R7
        '{1'b1, 1'b0, 16'd3,     64'h0,                   5'd9,  1'b1, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 8'd7},  // R7
        '{1'b1, 1'b1, 16'd4,     64'h0000_0000_0000_0099, 5'd9,  1'b0, 1'b0, 1'b1, 64'h0,                   8'd9},  // R9
        '{1'b1, 1'b0, 16'd4,     64'h0,                   5'd9,  1'b0, 1'b0, 1'b1, 64'h0,                   8'd9},  // R9
        '{1'b1, 1'b0, 16'd4,     64'h0,                   5'd9,  1'b1, 1'b1, 1'b0, 64'h0,                   8'd9},  // R9
        '{1'b0, 1'b1, 16'd4,     64'h0000_0000_0000_FFFF, 5'd9,  1'b1, 1'b0, 1'b0, 64'h0,                   8'd11}, // R11
        '{1'b1, 1'b0, 16'd4,     64'h0,                   5'd9,  1'b1, 1'b1, 1'b0, 64'h0,                   8'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_regnum = '0;
    logic [63:0] req_wdata = '0;
    logic [4:0]  req_gpr = '0;
    logic        priv_mode = 1'b0;
    logic [63:0] rsp_rdata;
    logic        rsp_wen;
    logic        rsp_illegal;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    privreg_file uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_regnum (req_regnum),
        .req_wdata  (req_wdata),
        .req_gpr    (req_gpr),
        .priv_mode  (priv_mode),
        .rsp_rdata  (rsp_rdata),
        .rsp_wen    (rsp_wen),
        .rsp_illegal(rsp_illegal)
    );

    task automatic check(input string req, input logic wen, input logic ill, input logic [63:0] rd);
        n_checks++;
        if (rsp_wen !== wen || rsp_illegal !== ill || rsp_rdata !== rd) begin
            n_fails++;
            $display("FAIL %s: got wen=%0b ill=%0b rd=%h, expected wen=%0b ill=%0b rd=%h",
                     req, rsp_wen, rsp_illegal, rsp_rdata, wen, ill, rd);
        end
    endtask

    // Drive at a falling edge; response is sampled at the next falling edge
    task automatic issue(input logic v, input logic wr, input logic [15:0] num,
                         input logic [63:0] data, input logic [4:0] gpr, input logic priv);
        req_valid  = v;
        req_write  = wr;
        req_regnum = num;
        req_wdata  = data;
        req_gpr    = gpr;
        priv_mode  = priv;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            n_fails++;
            $display("FAIL watchdog: got cycles=%0d, expected below 5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", 1'b0, 1'b0, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", 1'b0, 1'b0, 64'h0);

        for (int i = 0; i < NV; i++) begin
            issue(VT[i].v, VT[i].wr, VT[i].num, VT[i].data, VT[i].gpr, VT[i].priv);
            check($sformatf("R%0d vector %0d", VT[i].tag, i), VT[i].e_wen, VT[i].e_ill, VT[i].e_rd);
        end

        // R1: a second reset restores fen and clears written registers
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        issue(1'b1, 1'b0, 16'd1, 64'h0, 5'd2, 1'b1);
        check("R1 fen after re-reset", 1'b1, 1'b0, 64'h1);
        issue(1'b1, 1'b0, 16'd40, 64'h0, 5'd2, 1'b1);
        check("R1 scratch after re-reset", 1'b1, 1'b0, 64'h0);
        issue(1'b1, 1'b0, 16'd2, 64'h0, 5'd2, 1'b1);
        check("R1 counter offset after re-reset", 1'b1, 1'b0, 64'h0);

        // R10: write then immediate read, then an idle cycle clears the response
        issue(1'b1, 1'b1, 16'd11, 64'h5A5A_0000_1234_0000, 5'd2, 1'b1);
        check("R10 write gives no response", 1'b0, 1'b0, 64'h0);
        issue(1'b1, 1'b0, 16'd11, 64'h0, 5'd2, 1'b1);
        check("R10 read back next cycle", 1'b1, 1'b0, 64'h5A5A_0000_1234_0000);
        @(negedge clk);
        check("R10 pulse lasts one cycle", 1'b0, 1'b0, 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule